// File: doc/BRIEF.md
# Power-Good and Fault Flag Logic

This block turns the digitized comparator flags of a hot-swap and ORing power controller into two system-facing signals: a power-good output that tells downstream converters they may start, and an active-low fault output. The comparators themselves sit outside the block. Every input arrives as a single-bit flag that is already synchronous to the block clock.

Power-good uses two VDS thresholds with asymmetric filtering. It sets only after a short qualification, and only while hot-swap is enabled and the pass-FET drop is under the low threshold. It clears only after a longer qualification, when one of three causes holds: hot-swap is disabled, the drop is over the high threshold, or the protection timer has latched the switch off. When the drop lies between the two thresholds, power-good holds its state.

The fault output is the registered OR of five conditions:

- a shorted pass FET, where current is still seen while hot-swap is disabled;
- a timer latch-off;
- an ORing FET that has been commanded on but still drops too much;
- a charge pump that has stayed down for a qualification window;
- over-temperature.

All filter lengths are parameters in clock cycles.

Top module: `pgf_flag_logic`

## Requirements
- R1: When `hs_en`=1, `vds_lo`=1 and no off cause is present on every clock edge for PG_ON_CYC consecutive edges, `pg` rises on the next edge (PG_ON_CYC+1 edges after the first qualifying edge). It does not rise earlier.
- R2: An off cause is `hs_en`=0, `vds_hi`=1 or `tmo_latched`=1. When off causes are present on PG_OFF_CYC consecutive edges while `pg`=1, `pg` falls on the next edge (PG_OFF_CYC+1 edges). It does not fall earlier.
- R3: With `hs_en`=1, `tmo_latched`=0, `vds_lo`=0 and `vds_hi`=0, `pg` keeps its present value indefinitely, whether that value is 0 or 1.
- R4: `hs_en`=0 with `imon_short`=1 drives `fault_n` low one edge later.
- R5: `tmo_latched`=1 drives `fault_n` low one edge later.
- R6: `or_en`=1, `cp_up`=1 and `or_drop_hi`=1 together drive `fault_n` low one edge later. If any one of the three is 0, this condition does not contribute.
- R7: `over_temp`=1 drives `fault_n` low one edge later.
- R8: If `cp_up` is 0 on CP_DOWN_CYC consecutive edges, `fault_n` goes low one edge after that (CP_DOWN_CYC+1 edges after the first low edge). A shorter low interval does not produce a fault.
- R9: Any interruption of a qualifying condition restarts its count from zero. This applies to the power-good set filter, the power-good clear filter and the charge-pump filter.
- R10: While synchronous reset `rst` is high, and on the first edge after it, `pg`=0 and `fault_n`=1.
- R11: `fault_n` returns to 1 one edge after all five fault conditions are absent. It is exactly the inverse of the OR of R4 to R8, in every input combination.
- R12: If `vds_lo` and `vds_hi` are both 1, the off cause wins: `pg` never sets and, when it is set, it clears per R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_en | input | 1 | Hot-swap section enabled |
| vds_lo | input | 1 | Pass-FET drop below low threshold |
| vds_hi | input | 1 | Pass-FET drop above high threshold |
| tmo_latched | input | 1 | Protection timer has latched the switch off |
| imon_short | input | 1 | Current monitor above shorted-FET level |
| or_en | input | 1 | ORing section enabled |
| cp_up | input | 1 | Charge pump is up |
| or_drop_hi | input | 1 | ORing FET drop above open-FET level |
| over_temp | input | 1 | Over-temperature flag |
| pg | output | 1 | Power-good, deglitched |
| fault_n | output | 1 | Fault, active low |

## Verification
A counter that restarts late or saturates early moves the edge of `pg` or `fault_n` by one or more cycles. The bench therefore samples one edge before and one edge on each expected transition, so an off-by-one delay shows within a single filter window. A wrong term in the fault OR shows one edge after the matching input combination is applied, and the sweep over all 128 fault-input combinations exposes it. A lost hysteresis state shows as `pg` changing while both VDS flags are low.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    typedef struct packed {
        logic hs_en;
        logic vds_lo;
        logic vds_hi;
        logic tmo_latched;
        logic imon_short;
        logic or_en;
        logic cp_up;
        logic or_drop_hi;
        logic over_temp;
    } pgf_flags_t;

    typedef enum logic {
        PG_LOW  = 1'b0,
        PG_HIGH = 1'b1
    } pg_state_e;

    function automatic int unsigned cnt_bits(input int unsigned limit);
        int unsigned b;
        b = $clog2(limit + 1);
        return (b < 1) ? 1 : b;
    endfunction

endpackage

// File: rtl/pgf_deglitch.sv
module pgf_deglitch #(
    parameter int unsigned DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    output logic done
);
    localparam int unsigned W = pgf_pkg::cnt_bits(DELAY);
    localparam logic [W-1:0] LIMIT = W'(DELAY);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !cond) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIMIT);

    // R9: an interrupted condition can never leave the filter qualified
    assert_drop_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !cond |=> !done);

endmodule

// File: rtl/pgf_pg_ctrl.sv
module pgf_pg_ctrl #(
    parameter int unsigned ON_CYC  = 4,
    parameter int unsigned OFF_CYC = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  pgf_pkg::pgf_flags_t flags,
    output logic                pg
);
    import pgf_pkg::*;

    logic      off_cause, on_cause;
    logic      on_done, off_done;
    pg_state_e st_q;

    assign off_cause = !flags.hs_en || flags.vds_hi || flags.tmo_latched;
    assign on_cause  = flags.hs_en && flags.vds_lo && !off_cause;

    pgf_deglitch #(.DELAY(ON_CYC)) on_filt_i (
        .clk (clk),
        .rst (rst),
        .cond(on_cause),
        .done(on_done)
    );

    pgf_deglitch #(.DELAY(OFF_CYC)) off_filt_i (
        .clk (clk),
        .rst (rst),
        .cond(off_cause),
        .done(off_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PG_LOW;
        end else begin
            unique case (st_q)
                PG_LOW:  if (on_done)  st_q <= PG_HIGH;
                PG_HIGH: if (off_done) st_q <= PG_LOW;
                default: st_q <= PG_LOW;
            endcase
        end
    end

    assign pg = (st_q == PG_HIGH);

    assert_pg_rise_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(pg) |-> $past(flags.hs_en && flags.vds_lo && !flags.vds_hi && !flags.tmo_latched));

    assert_pg_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(pg) |-> $past(!flags.hs_en || flags.vds_hi || flags.tmo_latched));

    assert_pg_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (flags.hs_en && !flags.tmo_latched && !flags.vds_lo && !flags.vds_hi) |=> $stable(pg));

endmodule

// File: rtl/pgf_fault_merge.sv
module pgf_fault_merge #(
    parameter int unsigned CP_CYC = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  pgf_pkg::pgf_flags_t flags,
    output logic                fault_n
);
    localparam int unsigned N_SRC = 5;

    logic [N_SRC-1:0] src;
    logic             cp_done;
    logic             flt_q;

    pgf_deglitch #(.DELAY(CP_CYC)) cp_filt_i (
        .clk (clk),
        .rst (rst),
        .cond(!flags.cp_up),
        .done(cp_done)
    );

    assign src[0] = !flags.hs_en && flags.imon_short;
    assign src[1] = flags.tmo_latched;
    assign src[2] = flags.or_en && flags.cp_up && flags.or_drop_hi;
    assign src[3] = cp_done;
    assign src[4] = flags.over_temp;

    always_ff @(posedge clk) begin
        if (rst) flt_q <= 1'b0;
        else     flt_q <= |src;
    end

    assign fault_n = !flt_q;

    assert_short_fault_R4: assert property (@(posedge clk) disable iff (rst)
        (!flags.hs_en && flags.imon_short) |=> !fault_n);

    assert_timeout_fault_R5: assert property (@(posedge clk) disable iff (rst)
        flags.tmo_latched |=> !fault_n);

    assert_oring_open_R6: assert property (@(posedge clk) disable iff (rst)
        (flags.or_en && flags.cp_up && flags.or_drop_hi) |=> !fault_n);

    assert_overtemp_R7: assert property (@(posedge clk) disable iff (rst)
        flags.over_temp |=> !fault_n);

endmodule

// File: rtl/pgf_flag_logic.sv
module pgf_flag_logic #(
    parameter int unsigned PG_ON_CYC   = 125000,
    parameter int unsigned PG_OFF_CYC  = 1000000,
    parameter int unsigned CP_DOWN_CYC = 4000000
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_en,
    input  logic vds_lo,
    input  logic vds_hi,
    input  logic tmo_latched,
    input  logic imon_short,
    input  logic or_en,
    input  logic cp_up,
    input  logic or_drop_hi,
    input  logic over_temp,
    output logic pg,
    output logic fault_n
);
    import pgf_pkg::*;

    pgf_flags_t flags;

    always_comb begin
        flags.hs_en       = hs_en;
        flags.vds_lo      = vds_lo;
        flags.vds_hi      = vds_hi;
        flags.tmo_latched = tmo_latched;
        flags.imon_short  = imon_short;
        flags.or_en       = or_en;
        flags.cp_up       = cp_up;
        flags.or_drop_hi  = or_drop_hi;
        flags.over_temp   = over_temp;
    end

    pgf_pg_ctrl #(.ON_CYC(PG_ON_CYC), .OFF_CYC(PG_OFF_CYC)) pg_i (
        .clk  (clk),
        .rst  (rst),
        .flags(flags),
        .pg   (pg)
    );

    pgf_fault_merge #(.CP_CYC(CP_DOWN_CYC)) flt_i (
        .clk    (clk),
        .rst    (rst),
        .flags  (flags),
        .fault_n(fault_n)
    );

    assert_reset_state_R10: assert property (@(posedge clk)
        $past(rst) |-> (!pg && fault_n));

endmodule

// File: tb/pgf_flag_logic_tb.sv
module pgf_flag_logic_tb_top;
    localparam int unsigned ON  = 6;
    localparam int unsigned OFF = 10;
    localparam int unsigned CP  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hs_en = 0, vds_lo = 0, vds_hi = 0, tmo_latched = 0, imon_short = 0;
    logic or_en = 0, cp_up = 1, or_drop_hi = 0, over_temp = 0;
    logic pg, fault_n;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pgf_flag_logic #(.PG_ON_CYC(ON), .PG_OFF_CYC(OFF), .CP_DOWN_CYC(CP)) dut_i (
        .clk(clk), .rst(rst), .hs_en(hs_en), .vds_lo(vds_lo), .vds_hi(vds_hi),
        .tmo_latched(tmo_latched), .imon_short(imon_short), .or_en(or_en),
        .cp_up(cp_up), .or_drop_hi(or_drop_hi), .over_temp(over_temp),
        .pg(pg), .fault_n(fault_n)
    );

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic neutral();
        hs_en = 1; vds_lo = 0; vds_hi = 0; tmo_latched = 0; imon_short = 0;
        or_en = 0; cp_up = 1; or_drop_hi = 0; over_temp = 0;
    endtask

    task automatic raise_pg();
        neutral(); vds_lo = 1;
        adv(ON + 1);
        chk("R1 setup", pg, 1'b1);
        vds_lo = 0;
        adv(1);
    endtask

    task automatic drop_pg();
        neutral(); vds_hi = 1;
        adv(OFF + 1);
        chk("R2 setup", pg, 1'b0);
        vds_hi = 0;
        adv(1);
    endtask

    initial begin
        @(negedge clk);
        neutral(); hs_en = 0;
        rst = 1;
        adv(3);
        chk("R10 pg in reset", pg, 1'b0);
        chk("R10 fault_n in reset", fault_n, 1'b1);
        rst = 0;
        adv(1);
        chk("R10 pg after reset", pg, 1'b0);
        chk("R10 fault_n after reset", fault_n, 1'b1);
        neutral();
        adv(1);

        // R1: set timing
        vds_lo = 1;
        adv(ON);
        chk("R1 pg not early", pg, 1'b0);
        adv(1);
        chk("R1 pg set", pg, 1'b1);

        // R3: hold high in band
        vds_lo = 0;
        adv(OFF + 5);
        chk("R3 hold high", pg, 1'b1);

        // R2 across each off cause, plus R9 clear-filter restart
        for (int c = 0; c < 3; c++) begin
            neutral();
            if (c == 0) hs_en = 0;
            if (c == 1) vds_hi = 1;
            if (c == 2) tmo_latched = 1;
            adv(OFF - 1);
            neutral();
            adv(1);
            chk("R9 clear filter restart", pg, 1'b1);
            if (c == 0) hs_en = 0;
            if (c == 1) vds_hi = 1;
            if (c == 2) tmo_latched = 1;
            adv(OFF);
            chk("R2 pg not early", pg, 1'b0 ^ 1'b1);
            adv(1);
            chk("R2 pg cleared", pg, 1'b0);
            neutral();
            adv(1);
            if (c < 2) raise_pg();
        end

        // R3: hold low in band
        neutral();
        adv(ON + 5);
        chk("R3 hold low", pg, 1'b0);

        // R9: set filter restart
        vds_lo = 1;
        adv(ON - 1);
        vds_lo = 0;
        adv(1);
        vds_lo = 1;
        adv(ON);
        chk("R9 set filter restart", pg, 1'b0);
        adv(1);
        chk("R9 set after full window", pg, 1'b1);

        // R12: both vds flags high
        vds_hi = 1;
        adv(OFF + 1);
        chk("R12 both flags clear pg", pg, 1'b0);
        adv(ON + 3);
        chk("R12 both flags never set", pg, 1'b0);
        neutral();
        adv(1);

        // Directed fault checks
        imon_short = 1; hs_en = 0;
        adv(1);
        chk("R4 shorted FET", fault_n, 1'b0);
        neutral(); adv(1);
        chk("R11 release", fault_n, 1'b1);
        imon_short = 1;
        adv(1);
        chk("R4 no fault when enabled", fault_n, 1'b1);
        neutral();
        tmo_latched = 1; adv(1);
        chk("R5 timeout", fault_n, 1'b0);
        neutral(); or_en = 1; or_drop_hi = 1; adv(1);
        chk("R6 ORing open", fault_n, 1'b0);
        neutral(); over_temp = 1; adv(1);
        chk("R7 over-temperature", fault_n, 1'b0);
        neutral(); adv(1);

        // R8 and R9 on charge pump
        cp_up = 0;
        adv(CP - 1);
        cp_up = 1;
        adv(1);
        chk("R9 cp filter restart", fault_n, 1'b1);
        cp_up = 0;
        adv(CP);
        chk("R8 cp not early", fault_n, 1'b1);
        adv(1);
        chk("R8 cp down fault", fault_n, 1'b0);
        cp_up = 1;
        adv(2);
        chk("R11 cp recovery", fault_n, 1'b1);

        // R11: sweep every fault-input combination
        for (int v = 0; v < 128; v++) begin
            logic e;
            neutral();
            adv(1);
            hs_en = v[0]; imon_short = v[1]; tmo_latched = v[2]; or_en = v[3];
            cp_up = v[4]; or_drop_hi = v[5]; over_temp = v[6];
            e = (!v[0] && v[1]) || v[2] || (v[3] && v[4] && v[5]) || v[6];
            adv(1);
            chk("R11 fault sweep", fault_n, !e);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule